// File: doc/BRIEF.md
# Sticky Interrupt Status Controller

This block gathers thirteen single-cycle event pulses from a serial peripheral into one level-sensitive interrupt line. Each pulse sets a bit in a status register that stays set until software clears it by writing a one to that bit. Masking is done through two write-only registers: writing ones to one of them unmasks sources, and writing ones to the other masks them. A third register shows the current mask when read.

The interrupt output is high whenever any status bit is set while its mask bit is also set. Status bits record events whether or not they are masked. Software can therefore poll sources it has masked, or unmask a source later and get an interrupt at once for an event that is already pending. The block is reached through a plain register port. Writes take effect at the clock edge. Reads are combinational from the address.

Top module: `sirq_aggregator`

## Requirements
- R1: After reset, the status register reads 0, the mask register reads 0, and `irq_out` is low.
- R2: A write to offset 0x08 sets each mask bit whose write-data bit is 1. Write-data bits that are 0 leave the mask unchanged. A write of all zeros changes nothing.
- R3: A write to offset 0x0C clears each mask bit whose write-data bit is 1. Write-data bits that are 0 leave the mask unchanged.
- R4: A read at offset 0x10 returns the current mask in bits 12:0. Bits 31:13 read as 0, even after ones have been written to those positions at 0x08.
- R5: A one on `ev_pulse[i]` sets status bit i at the next clock edge, whether or not source i is masked. The bit then stays set through any number of idle cycles. Source order in bits 0 to 12 is: receive trigger, receive empty, receive full, transmit empty, transmit full, receive overflow, framing error, parity error, receive timeout, modem status change, transmit trigger, transmit nearly full, transmit overflow.
- R6: A write to offset 0x14 clears exactly the status bits whose write-data bit is 1. A read at 0x14 returns the status in bits 12:0.
- R7: If an event pulse and a clear write hit the same status bit in the same cycle, the bit stays set.
- R8: `irq_out` is high exactly when some bit is set in both status and mask. A pending masked event raises `irq_out` in the cycle after its source is unmasked.
- R9: Reads at 0x08, 0x0C and any unmapped offset return 0. Writes to 0x10 or to an unmapped offset change neither mask nor status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_pulse | input | 13 | One-cycle event pulses, one per source |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_out | output | 1 | Interrupt request, level |

## Verification
A wrong status bit shows up on the port in one of two ways. It appears in the very next read of offset 0x14. If that source is unmasked, it also appears on `irq_out` one edge after the event or write that should have changed it. A wrong mask bit is visible just as quickly through offset 0x10. It also shows on `irq_out` as soon as a pending event sits under that mask bit. The bench therefore takes each source through the full cycle of event, unmask, mask and clear, reading back after every step. This way a lost update or a crossed bit cannot hide for more than one operation.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  localparam int unsigned OFS_IRQ_SET   = 'h08;
  localparam int unsigned OFS_IRQ_CLR   = 'h0C;
  localparam int unsigned OFS_IRQ_VIEW  = 'h10;
  localparam int unsigned OFS_IRQ_STAT  = 'h14;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_SET,
    SEL_CLR,
    SEL_VIEW,
    SEL_STAT
  } reg_sel_e;

endpackage

// File: rtl/sirq_addr_decode.sv
module sirq_addr_decode
  import sirq_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);

  always_comb begin
    if (addr == ADDR_W'(OFS_IRQ_SET))       sel = SEL_SET;
    else if (addr == ADDR_W'(OFS_IRQ_CLR))  sel = SEL_CLR;
    else if (addr == ADDR_W'(OFS_IRQ_VIEW)) sel = SEL_VIEW;
    else if (addr == ADDR_W'(OFS_IRQ_STAT)) sel = SEL_STAT;
    else                                    sel = SEL_NONE;
  end

endmodule

// File: rtl/sirq_mask_reg.sv
module sirq_mask_reg #(
  parameter int N_SRC = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] set_vec,
  input  logic [N_SRC-1:0] clr_vec,
  output logic [N_SRC-1:0] mask_q
);

  // Clearing has priority over setting for a bit named by both.
  function automatic logic [N_SRC-1:0] mask_update(
    input logic [N_SRC-1:0] cur,
    input logic [N_SRC-1:0] s,
    input logic [N_SRC-1:0] c
  );
    return (cur | s) & ~c;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_update(mask_q, set_vec, clr_vec);
  end

  AST_MASK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_vec != '0) && (clr_vec == '0)) |=> ((mask_q & $past(set_vec)) == $past(set_vec))); // R2
  AST_MASK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec != '0) |=> ((mask_q & $past(clr_vec)) == '0)); // R3
  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_vec == '0) && (clr_vec == '0)) |=> $stable(mask_q)); // R2

endmodule

// File: rtl/sirq_status_reg.sv
module sirq_status_reg #(
  parameter int N_SRC = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] ev_in,
  input  logic [N_SRC-1:0] w1c_vec,
  output logic [N_SRC-1:0] status_q
);

  // An event in the same cycle as a clear keeps the bit set.
  function automatic logic [N_SRC-1:0] status_update(
    input logic [N_SRC-1:0] cur,
    input logic [N_SRC-1:0] ev,
    input logic [N_SRC-1:0] w1c
  );
    return (cur & ~w1c) | ev;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_update(status_q, ev_in, w1c_vec);
  end

  AST_EVENT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_in != '0) |=> ((status_q & $past(ev_in)) == $past(ev_in))); // R5
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (w1c_vec == '0) |=> ((($past(status_q)) & ~status_q) == '0)); // R5
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (w1c_vec != '0) |=> ((status_q & $past(w1c_vec) & ~$past(ev_in)) == '0)); // R6
  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ((w1c_vec & ev_in) != '0) |=> ((status_q & $past(w1c_vec & ev_in)) != '0)); // R7

endmodule

// File: rtl/sirq_aggregator.sv
module sirq_aggregator
  import sirq_pkg::*;
#(
  parameter int N_SRC  = 13,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  ev_pulse,
  input  logic              bus_wr_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_out
);

  localparam int HI_W = DATA_W - N_SRC;

  reg_sel_e         sel;
  logic [N_SRC-1:0] wr_bits;
  logic [N_SRC-1:0] set_vec;
  logic [N_SRC-1:0] clr_vec;
  logic [N_SRC-1:0] w1c_vec;
  logic [N_SRC-1:0] mask_q;
  logic [N_SRC-1:0] status_q;
  logic [N_SRC-1:0] pending;
  logic             unused_wdata_hi;

  assign wr_bits         = bus_wdata[N_SRC-1:0];
  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:DATA_W-HI_W];

  sirq_addr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (bus_addr),
    .sel  (sel)
  );

  assign set_vec = (bus_wr_en && sel == SEL_SET)  ? wr_bits : '0;
  assign clr_vec = (bus_wr_en && sel == SEL_CLR)  ? wr_bits : '0;
  assign w1c_vec = (bus_wr_en && sel == SEL_STAT) ? wr_bits : '0;

  sirq_mask_reg #(.N_SRC(N_SRC)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .mask_q  (mask_q)
  );

  sirq_status_reg #(.N_SRC(N_SRC)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_in    (ev_pulse),
    .w1c_vec  (w1c_vec),
    .status_q (status_q)
  );

  assign pending = status_q & mask_q;
  assign irq_out = |pending;

  always_comb begin
    unique case (sel)
      SEL_VIEW: bus_rdata = DATA_W'(mask_q);
      SEL_STAT: bus_rdata = DATA_W'(status_q);
      default:  bus_rdata = '0;
    endcase
  end

  AST_NO_IRQ_WHEN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_out); // R8
  AST_NO_IRQ_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == '0) |-> !irq_out); // R8
  AST_VIEW_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && (sel == SEL_VIEW || sel == SEL_NONE) && ev_pulse == '0)
      |=> ($stable(mask_q) && $stable(status_q))); // R9

endmodule

// File: tb/sirq_aggregator_tb.sv
`timescale 1ns/100ps
module sirq_aggregator_tb_top;

  localparam int N = 13;
  localparam logic [31:0] ALL = 32'h1FFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] ev_pulse = '0;
  logic        bus_wr_en = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int n_checks = 0;
  int n_errors = 0;
  logic [31:0] exp_mask = '0;
  logic [31:0] exp_stat = '0;

  always #2.5 clk = ~clk;

  sirq_aggregator dut_i (
    .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .bus_wr_en(bus_wr_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // All stimulus starts at a falling edge and ends at the next falling edge.
  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0; bus_wdata = '0;
  endtask

  task automatic pulse(input logic [N-1:0] e);
    ev_pulse = e;
    @(negedge clk);
    ev_pulse = '0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic exp_irq();
    return ((exp_stat & exp_mask) != 0);
  endfunction

  initial begin : wdog
    repeat (20000) @(posedge clk);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(6'h14, v); check("R1 status", v, 0);
    rd(6'h10, v); check("R1 mask", v, 0);
    check("R1 irq", {31'b0, irq_out}, 0);

    for (int i = 0; i < N; i++) begin
      logic [31:0] b;
      b = 32'h1 << i;
      pulse(N'(b)); exp_stat |= b;
      rd(6'h14, v); check("R5 latch masked", v, exp_stat);
      check("R8 masked no irq", {31'b0, irq_out}, 0);
      wr(6'h08, b); exp_mask |= b;
      rd(6'h10, v); check("R2/R4 enable bit", v, exp_mask);
      check("R8 irq on unmask", {31'b0, irq_out}, 1);
      wr(6'h0C, b); exp_mask &= ~b;
      rd(6'h10, v); check("R3 disable bit", v, exp_mask);
      check("R8 irq off", {31'b0, irq_out}, 0);
      wr(6'h14, b); exp_stat &= ~b;
      rd(6'h14, v); check("R6 clear bit", v, exp_stat);
    end

    wr(6'h08, 32'hFFFF_FFFF); exp_mask = ALL;
    rd(6'h10, v); check("R4 upper bits zero", v, ALL);
    wr(6'h0C, 32'h0000_00F0); exp_mask &= ~32'hF0;
    rd(6'h10, v); check("R3 zeros keep", v, 32'h1F0F);
    wr(6'h08, 32'h0); 
    rd(6'h10, v); check("R2 zero write", v, 32'h1F0F);

    pulse(13'h0A5A); exp_stat = 32'h0A5A;
    rd(6'h14, v); check("R5 pattern", v, exp_stat);
    check("R8 irq pattern", {31'b0, irq_out}, {31'b0, exp_irq()});
    wr(6'h14, 32'h0A00); exp_stat = 32'h005A;
    rd(6'h14, v); check("R6 partial clear", v, 32'h005A);

    // R7: event on bit 3 while clearing bits 3 and 4
    ev_pulse = 13'h0008;
    wr(6'h14, 32'h0018);
    ev_pulse = '0; exp_stat = 32'h004A;
    rd(6'h14, v); check("R7 event beats clear", v, 32'h004A);

    repeat (10) @(negedge clk);
    rd(6'h14, v); check("R5 sticky idle", v, 32'h004A);
    check("R8 irq pending", {31'b0, irq_out}, 1);

    wr(6'h10, 32'h0);
    rd(6'h10, v); check("R9 mask view write inert", v, 32'h1F0F);
    wr(6'h3C, 32'hFFFF_FFFF);
    rd(6'h10, v); check("R9 unmapped write mask", v, 32'h1F0F);
    rd(6'h14, v); check("R9 unmapped write status", v, 32'h004A);
    rd(6'h08, v); check("R9 read enable zero", v, 0);
    rd(6'h0C, v); check("R9 read disable zero", v, 0);
    rd(6'h3C, v); check("R9 read unmapped zero", v, 0);

    wr(6'h0C, ALL); exp_mask = 0;
    check("R8 irq low all masked", {31'b0, irq_out}, 0);
    rd(6'h14, v); check("R5 status kept when masked", v, 32'h004A);
    wr(6'h14, ALL); exp_stat = 0;
    rd(6'h14, v); check("R6 clear all", v, 0);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule